// File: doc/BRIEF.md
# Operand Addressing-Mode Decoder

This block resolves one 6-bit operand field of a 16-bit, word-addressed processor into two things: the value the operand supplies and the place a result would be written to. It reads the eight general registers, the stack pointer, the program counter and the overflow register from its inputs. It reaches word memory through one read port with a combinational return path. Some codes take an extension word that follows the instruction word. For those the block first fetches that word at the program counter, and it then reports a program-counter step and one extra cycle of cost. The stack codes report the new stack-pointer value as well as the memory slot they use.

The sequencer around the block pulses `start` with a code and holds every input steady until `done`. The number of cycles depends on how many memory reads the code needs: none, one or two. When `done` is high for its single cycle, the block presents the value, the write target, the write-block flag, the stack-pointer and program-counter update strobes and the extra-cycle count. A skipped instruction is decoded with `skip` high. In that case the only effect is a program-counter step for the codes that carry an extension word. When an instruction has two operands, the caller decodes the destination operand first, applies its stack-pointer and program-counter updates, and then decodes the source operand.

Top module: `opnd_decoder`

## Requirements
- R1: Codes 0x00 to 0x07 select a general register directly. The register index equals the code, in the order A, B, C, X, Y, Z, I, J on `gpr_vec` (index k is bits 16k+15:16k). `done` reports the register value, target kind 1 (register) and `tgt_reg` equal to the index, and the block makes no memory read.
- R2: Codes 0x08 to 0x0F make one memory read at the address held in register (code & 7). That word is the value, and the target is kind 5 (memory) at that address.
- R3: Codes 0x10 to 0x17 first read the extension word at PC. They then read memory at (extension word + register (code & 7)) modulo 2^16, which is also the memory target. They raise `pc_we` with `pc_next` = PC+1 and report an extra cycle count of 1.
- R4: Code 0x18 reads memory at SP and reports `sp_next` = SP+1. Code 0x19 reads memory at SP and leaves SP unchanged (`sp_we` low). Code 0x1A uses address SP−1 and reports `sp_next` = SP−1. All stack arithmetic wraps modulo 2^16, and the memory target is the address that was used.
- R5: Codes 0x1B, 0x1C and 0x1D give the value of SP, PC and the overflow register, with target kinds 2, 3 and 4. They make no memory read.
- R6: Code 0x1E reads the extension word at PC and then memory at that word (memory target). Code 0x1F uses the extension word itself as the value. Both codes report `pc_we`, `pc_next` = PC+1 and an extra cycle count of 1.
- R7: Codes 0x20 to 0x3F give the value (code − 0x20) with no memory read, no PC step and an extra cycle count of 0.
- R8: For every code from 0x1F upward, `write_block` is high at `done` and the target kind is 0 (none). For every code below 0x1F, `write_block` is low.
- R9: With `skip` high, codes 0x10–0x17, 0x1E and 0x1F make exactly one memory read, at PC, and report `pc_we` with `pc_next` = PC+1. All other codes make no read. In skip mode every code reports `sp_we` low, an extra cycle count of 0, target kind 0, value 0 and `write_block` high.
- R10: After the clock edge that samples `start`, `mem_rd` is high for one cycle per memory read, in the order extension word first and operand word second. `done` follows for exactly one cycle, and then `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin decoding `code`; taken only when not busy |
| skip | input | 1 | Skip-mode decode (PC step only) |
| code | input | 6 | Operand field |
| gpr_vec | input | 128 | Eight general registers, index 0 in the low bits |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Current program counter (points at the extension word) |
| ovf_in | input | 16 | Current overflow register |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, same cycle as address |
| busy | output | 1 | A decode is in progress |
| done | output | 1 | Result valid, one cycle |
| value | output | 16 | Operand value |
| tgt | output | 3 | Target kind: 0 none, 1 register, 2 SP, 3 PC, 4 overflow, 5 memory |
| tgt_reg | output | 3 | Register index when target kind is 1 |
| tgt_addr | output | 16 | Memory address when target kind is 5 |
| write_block | output | 1 | Writes to this operand must be dropped |
| sp_we | output | 1 | Apply `sp_next` to SP |
| sp_next | output | 16 | New stack pointer |
| pc_we | output | 1 | Apply `pc_next` to PC |
| pc_next | output | 16 | New program counter |
| extra_cyc | output | 2 | Extra cycles this operand costs |

## Verification
The indexed codes 0x10–0x17 complete two things at once: the program-counter step for the extension word, and the formation of the memory address from that word plus a register. Both show up in the same `done` cycle. The bench drives this case with a register value that makes the 16-bit sum wrap. It then checks `pc_next`, `tgt_addr`, `value` and both read addresses against its own model. The push code is handled the same way: its stack-pointer decrement and its memory target fall together, and the bench checks them with SP at zero so that the decrement wraps.

// File: rtl/opd_pkg.sv
package opd_pkg;

   typedef enum logic [2:0] {
      TGT_NONE = 3'd0,
      TGT_GPR  = 3'd1,
      TGT_SP   = 3'd2,
      TGT_PC   = 3'd3,
      TGT_OVF  = 3'd4,
      TGT_MEM  = 3'd5
   } tgt_e;

   typedef enum logic [3:0] {
      K_GPR,
      K_GPR_IND,
      K_GPR_IDX,
      K_POP,
      K_PEEK,
      K_PUSH,
      K_SP,
      K_PC,
      K_OVF,
      K_EXT_IND,
      K_EXT_LIT,
      K_SHORT_LIT
   } kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EXT,
      ST_MEM,
      ST_DONE
   } st_e;

   typedef struct packed {
      kind_e kind;
      logic  use_ext;
      logic  use_mem;
      logic  is_lit;
   } cls_t;

endpackage

// File: rtl/opd_classify.sv
module opd_classify
   import opd_pkg::*;
#(
   parameter int CODE_W = 6,
   parameter int RIDX_W = 3
) (
   input  logic [CODE_W-1:0] code,
   output cls_t              cls,
   output logic [RIDX_W-1:0] ridx
);
   localparam int GRP_W = CODE_W - RIDX_W;

   logic [GRP_W-1:0] grp;

   assign grp  = code[CODE_W-1:RIDX_W];
   assign ridx = code[RIDX_W-1:0];

   always_comb begin
      cls.kind    = K_SHORT_LIT;
      cls.use_ext = 1'b0;
      cls.use_mem = 1'b0;
      cls.is_lit  = 1'b1;
      if (grp == GRP_W'(0)) begin
         cls.kind   = K_GPR;
         cls.is_lit = 1'b0;
      end else if (grp == GRP_W'(1)) begin
         cls.kind    = K_GPR_IND;
         cls.use_mem = 1'b1;
         cls.is_lit  = 1'b0;
      end else if (grp == GRP_W'(2)) begin
         cls.kind    = K_GPR_IDX;
         cls.use_ext = 1'b1;
         cls.use_mem = 1'b1;
         cls.is_lit  = 1'b0;
      end else if (grp == GRP_W'(3)) begin
         cls.is_lit = 1'b0;
         case (ridx)
            RIDX_W'(0): begin cls.kind = K_POP;  cls.use_mem = 1'b1; end
            RIDX_W'(1): begin cls.kind = K_PEEK; cls.use_mem = 1'b1; end
            RIDX_W'(2): begin cls.kind = K_PUSH; cls.use_mem = 1'b1; end
            RIDX_W'(3): cls.kind = K_SP;
            RIDX_W'(4): cls.kind = K_PC;
            RIDX_W'(5): cls.kind = K_OVF;
            RIDX_W'(6): begin
               cls.kind    = K_EXT_IND;
               cls.use_ext = 1'b1;
               cls.use_mem = 1'b1;
            end
            default: begin
               cls.kind    = K_EXT_LIT;
               cls.use_ext = 1'b1;
               cls.is_lit  = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/opd_addr_gen.sv
module opd_addr_gen
   import opd_pkg::*;
#(
   parameter int DW = 16
) (
   input  kind_e         kind,
   input  logic [DW-1:0] reg_val,
   input  logic [DW-1:0] sp_in,
   input  logic [DW-1:0] ext_word,
   output logic [DW-1:0] addr,
   output logic [DW-1:0] sp_nx,
   output logic          sp_chg
);
   logic [DW-1:0] sp_inc;
   logic [DW-1:0] sp_dec;

   assign sp_inc = sp_in + DW'(1);
   assign sp_dec = sp_in - DW'(1);

   always_comb begin
      addr   = '0;
      sp_nx  = sp_in;
      sp_chg = 1'b0;
      case (kind)
         K_GPR_IND: addr = reg_val;
         K_GPR_IDX: addr = ext_word + reg_val;
         K_POP: begin
            addr   = sp_in;
            sp_nx  = sp_inc;
            sp_chg = 1'b1;
         end
         K_PEEK:    addr = sp_in;
         K_PUSH: begin
            addr   = sp_dec;
            sp_nx  = sp_dec;
            sp_chg = 1'b1;
         end
         K_EXT_IND: addr = ext_word;
         default:   addr = '0;
      endcase
   end

endmodule

// File: rtl/opd_seq.sv
module opd_seq
   import opd_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          skip,
   input  logic          use_ext,
   input  logic          use_mem,
   input  logic [DW-1:0] mem_rdata,
   output st_e           st,
   output logic          in_ext,
   output logic          in_mem,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] ext_q,
   output logic [DW-1:0] data_q
);
   st_e  st_nx;
   logic need_mem;

   assign need_mem = use_mem & ~skip;

   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE: if (start) st_nx = use_ext ? ST_EXT : (need_mem ? ST_MEM : ST_DONE);
         ST_EXT:  st_nx = need_mem ? ST_MEM : ST_DONE;
         ST_MEM:  st_nx = ST_DONE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ext_q  <= '0;
         data_q <= '0;
      end else begin
         st <= st_nx;
         if (st == ST_EXT) ext_q  <= mem_rdata;
         if (st == ST_MEM) data_q <= mem_rdata;
      end
   end

   assign in_ext = (st == ST_EXT);
   assign in_mem = (st == ST_MEM);
   assign busy   = (st != ST_IDLE);
   assign done   = (st == ST_DONE);

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && !use_ext && !need_mem) |=> done);

endmodule

// File: rtl/opnd_decoder.sv
module opnd_decoder
   import opd_pkg::*;
#(
   parameter int DW          = 16,
   parameter int NREG        = 8,
   parameter int CODE_W      = 6,
   parameter int CYC_W       = 2,
   parameter bit REG_SEL_AO  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 skip,
   input  logic [CODE_W-1:0]    code,
   input  logic [NREG*DW-1:0]   gpr_vec,
   input  logic [DW-1:0]        sp_in,
   input  logic [DW-1:0]        pc_in,
   input  logic [DW-1:0]        ovf_in,
   output logic                 mem_rd,
   output logic [DW-1:0]        mem_addr,
   input  logic [DW-1:0]        mem_rdata,
   output logic                 busy,
   output logic                 done,
   output logic [DW-1:0]        value,
   output logic [2:0]           tgt,
   output logic [$clog2(NREG)-1:0] tgt_reg,
   output logic [DW-1:0]        tgt_addr,
   output logic                 write_block,
   output logic                 sp_we,
   output logic [DW-1:0]        sp_next,
   output logic                 pc_we,
   output logic [DW-1:0]        pc_next,
   output logic [CYC_W-1:0]     extra_cyc
);
   localparam int RIDX_W    = $clog2(NREG);
   localparam int SLIT_W    = CODE_W - 1;
   localparam int LIT_FIRST = (1 << (CODE_W - 1)) - 1;

   // elaboration-time parameter checks
   if (CODE_W != 6) begin : g_bad_code
      $error("opnd_decoder: CODE_W must be 6");
   end
   if (NREG != (1 << RIDX_W) || RIDX_W != 3) begin : g_bad_nreg
      $error("opnd_decoder: NREG must be 8");
   end
   if (DW < CODE_W) begin : g_bad_dw
      $error("opnd_decoder: DW too small");
   end
   if (CYC_W < 1) begin : g_bad_cyc
      $error("opnd_decoder: CYC_W must be at least 1");
   end

   cls_t              cls;
   logic [RIDX_W-1:0] ridx;
   logic [DW-1:0]     gpr_arr [NREG];
   logic [DW-1:0]     reg_sel;
   logic [DW-1:0]     op_addr;
   logic [DW-1:0]     sp_nx;
   logic              sp_chg;
   st_e               st;
   logic              in_ext;
   logic              in_mem;
   logic [DW-1:0]     ext_q;
   logic [DW-1:0]     data_q;
   tgt_e              tgt_k;

   for (genvar g = 0; g < NREG; g++) begin : g_unpack
      assign gpr_arr[g] = gpr_vec[g*DW +: DW];
   end

   if (REG_SEL_AO) begin : g_sel_ao
      logic [DW-1:0] terms [NREG];
      logic [DW-1:0] acc   [NREG+1];
      assign acc[0] = '0;
      for (genvar g = 0; g < NREG; g++) begin : g_term
         assign terms[g]  = gpr_arr[g] & {DW{ridx == RIDX_W'(g)}};
         assign acc[g+1]  = acc[g] | terms[g];
      end
      assign reg_sel = acc[NREG];
   end else begin : g_sel_idx
      assign reg_sel = gpr_arr[ridx];
   end

   opd_classify #(.CODE_W(CODE_W), .RIDX_W(RIDX_W)) i_classify (
      .code (code),
      .cls  (cls),
      .ridx (ridx)
   );

   opd_addr_gen #(.DW(DW)) i_addr_gen (
      .kind     (cls.kind),
      .reg_val  (reg_sel),
      .sp_in    (sp_in),
      .ext_word (ext_q),
      .addr     (op_addr),
      .sp_nx    (sp_nx),
      .sp_chg   (sp_chg)
   );

   opd_seq #(.DW(DW)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .skip      (skip),
      .use_ext   (cls.use_ext),
      .use_mem   (cls.use_mem),
      .mem_rdata (mem_rdata),
      .st        (st),
      .in_ext    (in_ext),
      .in_mem    (in_mem),
      .busy      (busy),
      .done      (done),
      .ext_q     (ext_q),
      .data_q    (data_q)
   );

   assign mem_rd   = in_ext | in_mem;
   assign mem_addr = in_ext ? pc_in : (in_mem ? op_addr : '0);

   always_comb begin
      value       = '0;
      tgt_k       = TGT_NONE;
      tgt_reg     = '0;
      tgt_addr    = '0;
      write_block = 1'b0;
      sp_we       = 1'b0;
      pc_we       = 1'b0;
      extra_cyc   = '0;
      if (done) begin
         pc_we = cls.use_ext;
         if (skip) begin
            write_block = 1'b1;
         end else begin
            sp_we       = sp_chg;
            write_block = cls.is_lit;
            if (cls.use_ext) extra_cyc = CYC_W'(1);
            case (cls.kind)
               K_GPR: begin
                  value   = reg_sel;
                  tgt_k   = TGT_GPR;
                  tgt_reg = ridx;
               end
               K_GPR_IND, K_GPR_IDX, K_POP, K_PEEK, K_PUSH, K_EXT_IND: begin
                  value    = data_q;
                  tgt_k    = TGT_MEM;
                  tgt_addr = op_addr;
               end
               K_SP: begin
                  value = sp_in;
                  tgt_k = TGT_SP;
               end
               K_PC: begin
                  value = pc_in;
                  tgt_k = TGT_PC;
               end
               K_OVF: begin
                  value = ovf_in;
                  tgt_k = TGT_OVF;
               end
               K_EXT_LIT: value = ext_q;
               default:   value = DW'(code[SLIT_W-1:0]);
            endcase
         end
      end
   end

   assign tgt     = tgt_k;
   assign sp_next = sp_we ? sp_nx : sp_in;
   assign pc_next = pc_we ? (pc_in + DW'(1)) : pc_in;

   // R9
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && skip) |-> (!sp_we && extra_cyc == '0 && tgt == 3'd0 && write_block));

   // R3
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we |-> (pc_next == pc_in + DW'(1)));

   // R6
   ext_fetch_at_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && cls.use_ext) |=> (mem_rd && mem_addr == $past(pc_in)));

   // R8
   lit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !skip && code >= CODE_W'(LIT_FIRST)) |-> (write_block && tgt == 3'd0));

   // R4
   stack_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we |-> (done && (sp_next == sp_in + DW'(1) || sp_next == sp_in - DW'(1))));

endmodule

// File: tb/test_opnd_decoder.sv
module test_opnd_decoder;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        skip = 1'b0;
   logic [5:0]  code = '0;
   logic [15:0] rg [8];
   logic [127:0] gpr_vec;
   logic [15:0] sp_in = '0;
   logic [15:0] pc_in = '0;
   logic [15:0] ovf_in = '0;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [15:0] mem_rdata;
   logic        busy;
   logic        done;
   logic [15:0] value;
   logic [2:0]  tgt;
   logic [2:0]  tgt_reg;
   logic [15:0] tgt_addr;
   logic        write_block;
   logic        sp_we;
   logic [15:0] sp_next;
   logic        pc_we;
   logic [15:0] pc_next;
   logic [1:0]  extra_cyc;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] memf(input logic [15:0] a);
      return {a[7:0], a[15:8]} ^ 16'h5A3C;
   endfunction

   assign mem_rdata = memf(mem_addr);

   always_comb begin
      for (int k = 0; k < 8; k++) gpr_vec[k*16 +: 16] = rg[k];
   end

   opnd_decoder i_opnd_decoder (
      .clk(clk), .rst_n(rst_n), .start(start), .skip(skip), .code(code),
      .gpr_vec(gpr_vec), .sp_in(sp_in), .pc_in(pc_in), .ovf_in(ovf_in),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .value(value), .tgt(tgt), .tgt_reg(tgt_reg),
      .tgt_addr(tgt_addr), .write_block(write_block), .sp_we(sp_we),
      .sp_next(sp_next), .pc_we(pc_we), .pc_next(pc_next), .extra_cyc(extra_cyc)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [5:0] c, input bit sk);
      if (sk) return "R9";
      if (c < 6'h08) return "R1";
      if (c < 6'h10) return "R2";
      if (c < 6'h18) return "R3";
      if (c < 6'h1B) return "R4";
      if (c < 6'h1E) return "R5";
      if (c < 6'h20) return "R6";
      return "R7";
   endfunction

   // behavioural reference: expected reads and result for one decode
   task automatic run_case(input logic [5:0] c, input bit sk);
      logic [15:0] ea [2];
      int          nacc = 0;
      logic [15:0] e_val = '0, e_taddr = '0, e_spn = sp_in, e_pcn = pc_in, a;
      logic [2:0]  e_tgt = 3'd0, e_treg = 3'd0;
      logic        e_wb = 1'b0, e_spwe = 1'b0, e_pcwe = 1'b0;
      logic [1:0]  e_ex = 2'd0;
      logic [15:0] r  = rg[c[2:0]];
      logic [15:0] nw = memf(pc_in);
      bit          ext = (c >= 6'h10 && c <= 6'h17) || c == 6'h1E || c == 6'h1F;
      string       rq = req_of(c, sk);
      ea[0] = '0; ea[1] = '0;
      if (ext) begin
         nacc = 1; ea[0] = pc_in; e_pcwe = 1'b1; e_pcn = pc_in + 16'd1;
         if (!sk) e_ex = 2'd1;
      end
      if (sk) begin
         e_wb = 1'b1;
      end else if (c < 6'h08) begin
         e_val = r; e_tgt = 3'd1; e_treg = c[2:0];
      end else if (c < 6'h10) begin
         nacc = 1; ea[0] = r; e_val = memf(r); e_tgt = 3'd5; e_taddr = r;
      end else if (c < 6'h18) begin
         a = nw + r; nacc = 2; ea[1] = a; e_val = memf(a); e_tgt = 3'd5; e_taddr = a;
      end else if (c == 6'h18) begin
         nacc = 1; ea[0] = sp_in; e_val = memf(sp_in); e_tgt = 3'd5; e_taddr = sp_in;
         e_spwe = 1'b1; e_spn = sp_in + 16'd1;
      end else if (c == 6'h19) begin
         nacc = 1; ea[0] = sp_in; e_val = memf(sp_in); e_tgt = 3'd5; e_taddr = sp_in;
      end else if (c == 6'h1A) begin
         a = sp_in - 16'd1; nacc = 1; ea[0] = a; e_val = memf(a); e_tgt = 3'd5;
         e_taddr = a; e_spwe = 1'b1; e_spn = a;
      end else if (c == 6'h1B) begin
         e_val = sp_in; e_tgt = 3'd2;
      end else if (c == 6'h1C) begin
         e_val = pc_in; e_tgt = 3'd3;
      end else if (c == 6'h1D) begin
         e_val = ovf_in; e_tgt = 3'd4;
      end else if (c == 6'h1E) begin
         nacc = 2; ea[1] = nw; e_val = memf(nw); e_tgt = 3'd5; e_taddr = nw;
      end else if (c == 6'h1F) begin
         e_val = nw; e_wb = 1'b1;
      end else begin
         e_val = 16'(c - 6'h20); e_wb = 1'b1;
      end

      @(negedge clk);
      code = c; skip = sk; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i <= nacc; i++) begin
         chk(done == (i == nacc), "R10", "done timing", 32'(done), 32'(i == nacc));
         if (i < nacc) begin
            chk(mem_rd, "R10", "mem_rd", 32'(mem_rd), 32'd1);
            chk(mem_addr == ea[i], rq, "read address", 32'(mem_addr), 32'(ea[i]));
         end else begin
            chk(!mem_rd, "R10", "mem_rd idle", 32'(mem_rd), 32'd0);
            chk(value == e_val, rq, "value", 32'(value), 32'(e_val));
            chk(tgt == e_tgt, rq, "tgt", 32'(tgt), 32'(e_tgt));
            chk(tgt_reg == e_treg, rq, "tgt_reg", 32'(tgt_reg), 32'(e_treg));
            chk(tgt_addr == e_taddr, rq, "tgt_addr", 32'(tgt_addr), 32'(e_taddr));
            chk(write_block == e_wb, sk ? "R9" : "R8", "write_block",
                32'(write_block), 32'(e_wb));
            chk(sp_we == e_spwe && sp_next == e_spn, rq, "sp update",
                {15'd0, sp_we, sp_next}, {15'd0, e_spwe, e_spn});
            chk(pc_we == e_pcwe && pc_next == e_pcn, rq, "pc update",
                {15'd0, pc_we, pc_next}, {15'd0, e_pcwe, e_pcn});
            chk(extra_cyc == e_ex, rq, "extra_cyc", 32'(extra_cyc), 32'(e_ex));
         end
         @(negedge clk);
      end
      chk(!done && !busy, "R10", "return to idle", {done, busy}, 32'd0);
   endtask

   task automatic finish_report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog expired actual=hung expected=finish");
      finish_report();
   end

   initial begin
      for (int k = 0; k < 8; k++) rg[k] = 16'h1000 * 16'(k) + 16'h0011;
      repeat (3) @(negedge clk);
      chk(!done && !busy && !mem_rd && !sp_we && !pc_we, "R10", "reset state",
          {27'd0, done, busy, mem_rd, sp_we, pc_we}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: index sum wraps past 16 bits (ext word 0x5A3D + 0xB000)
      pc_in = 16'h0100; rg[2] = 16'hB000;
      run_case(6'h12, 1'b0);
      // R4: push from SP = 0 wraps to 0xFFFF, pop from 0xFFFF wraps to 0
      sp_in = 16'h0000; run_case(6'h1A, 1'b0);
      sp_in = 16'hFFFF; run_case(6'h18, 1'b0);
      sp_in = 16'h8000; run_case(6'h19, 1'b0);
      // R5 / R6 / R7 boundaries
      ovf_in = 16'hBEEF;
      run_case(6'h1D, 1'b0);
      run_case(6'h1E, 1'b0);
      run_case(6'h1F, 1'b0);
      run_case(6'h20, 1'b0);
      run_case(6'h3F, 1'b0);
      // R9: skip with extension word, stack code and register code
      run_case(6'h12, 1'b1);
      run_case(6'h1A, 1'b1);
      run_case(6'h05, 1'b1);

      // every code in both modes under varied state (R1..R9)
      for (int pass = 0; pass < 2; pass++) begin
         for (int c = 0; c < 64; c++) begin
            for (int k = 0; k < 8; k++)
               rg[k] = 16'(c * 16'h0731 + k * 16'h1111 + pass * 16'h4003);
            sp_in  = 16'(c * 16'h0405 + 16'h0003);
            pc_in  = 16'(c * 16'h0213 + 16'h0040);
            ovf_in = 16'(c * 16'h0101);
            run_case(6'(c), pass[0]);
         end
      end
      finish_report();
   end

endmodule